// File: doc/BRIEF.md
# Self-Test Status and Sequencing Register

This block keeps the global status of one built-in self-test run and drives the few control steps around it. A register bus reads a 32-bit status word. The word holds a completion flag, a failure flag and a 4-bit activity code. Software clears the two flags by writing ones while the bus is in privileged mode. The flags also clear when software moves the run-enable key from a disabled code to the enabled code.

The test engine reports three events: clean completion, a signature mismatch and a timeout. Each event sets the completion flag, and the last two also set the failure flag. A write to the core-select field starts a run and marks the status as active. When the completion flag rises, the block sends a one-cycle reset to the core that was selected. After that pulse the activity code returns to its idle value.

All controls are plain level or strobe pins with no handshake. The read word is always valid and has no read side effects. Only power-on reset returns the register to its reset value.

Top module: `bist_status_ctl`

## Requirements
- R1: After power-on reset the status word reads 0x0000_0500: activity code 0x5 in bits 11:8, and the failure flag (bit 1) and completion flag (bit 0) both 0. No core reset pulse is driven. A later power-on reset returns the word to this value from any state.
- R2: Bits 31:12 and 7:2 always read 0. Writing ones to these bits, or to the activity code in bits 11:8, changes nothing.
- R3: A status write with `bus_priv`=1 clears the completion flag when wdata bit 0 is 1, and clears the failure flag when wdata bit 1 is 1. Each flag clears independently, and the change shows after the next clock edge.
- R4: A status write with `bus_priv`=0, or a privileged write with a 0 in a flag's bit, leaves that flag unchanged.
- R5: A key write whose new value is 0xA, when the stored key is not 0xA, clears both flags on the next edge. Writing 0xA while the key is already 0xA clears nothing. The key resets to 0x5.
- R6: A core-select write makes the activity code read 0xA after the next clock edge.
- R7: An `evt_done` event sets only the completion flag. An `evt_fail` or `evt_timeout` event sets both flags. Each event takes effect on the edge that samples it.
- R8: When a set event and a clear (W1C write or key transition) reach the same flag in the same cycle, the flag ends up set.
- R9: When the completion flag rises after edge k, bit n of `core_rst` is high for exactly the one cycle after edge k+1. Here n is the last core-select value written, and no other bit is high.
- R10: On the edge that ends the reset pulse, the activity code returns to 0x5, unless a core-select write happens in that same cycle.
- R11: A completion flag that stays high produces no further pulse. A new 0-to-1 rise after a clear produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stat_wr | input | 1 | Write strobe for the status word |
| bus_priv | input | 1 | 1 when the bus access is privileged |
| bus_wdata | input | DATA_W | Status write data |
| stat_rdata | output | DATA_W | Status word readback |
| key_wr | input | 1 | Write strobe for the run-enable key |
| key_wdata | input | 4 | New run-enable key value |
| csel_wr | input | 1 | Write strobe for the core-select field (starts a run) |
| csel_wdata | input | CSEL_W | Index of the core under test |
| evt_done | input | 1 | Engine: run completed without mismatch |
| evt_fail | input | 1 | Engine: signature mismatch |
| evt_timeout | input | 1 | Engine: run timed out |
| core_rst | output | NUM_CORES | One-hot, one-cycle reset to the core under test |

## Verification
Every flag change becomes visible on `stat_rdata` one edge after its cause. A wrong set, clear or priority decision therefore appears at the next sample. A stale stored key shows up at the next enabling key write, as flags that stay set or clear when they should not. An error in the done-edge detector or the latched core index shows on `core_rst` two edges after the event, as a missing, repeated, long or misrouted pulse. The same error shows one edge later as an activity code that stays 0xA.

// File: rtl/bist_stat_pkg.sv
package bist_stat_pkg;
  localparam int          FLAG_NUM  = 2;
  localparam int          DONE_IDX  = 0;
  localparam int          FAIL_IDX  = 1;
  localparam int          CODE_W    = 4;
  localparam int          ACT_LSB   = 8;
  localparam logic [3:0]  KEY_ON    = 4'hA;
  localparam logic [3:0]  KEY_RST   = 4'h5;
  localparam logic [3:0]  ACT_RUN   = 4'hA;
  localparam logic [3:0]  ACT_IDLE  = 4'h5;

  typedef struct packed {
    logic [CODE_W-1:0]   act;
    logic [FLAG_NUM-1:0] flags;
  } stat_fields_t;
endpackage

// File: rtl/bist_key_watch.sv
module bist_key_watch
  import bist_stat_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              key_wr,
  input  logic [CODE_W-1:0] key_wdata,
  output logic              key_arm
);
  logic [CODE_W-1:0] key_q;

  // stored key, disabled code after power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      key_q <= KEY_RST;
    else if (key_wr) key_q <= key_wdata;
  end

  // one-cycle arm: a write that moves the key from any other value to the enabled code
  always_comb begin
    key_arm = key_wr && (key_wdata == KEY_ON) && (key_q != KEY_ON);
  end
endmodule

// File: rtl/bist_flag_cell.sv
module bist_flag_cell (
  input  logic clk,
  input  logic por_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  // sticky bit; a hardware set wins over any clear in the same cycle
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/bist_run_seq.sv
module bist_run_seq
  import bist_stat_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CSEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 csel_wr,
  input  logic [CSEL_W-1:0]    csel_wdata,
  input  logic                 done_q,
  output logic [CODE_W-1:0]    act_code,
  output logic [NUM_CORES-1:0] core_rst
);
  logic [CSEL_W-1:0] sel_q;
  logic [CODE_W-1:0] act_q;
  logic              done_d_q;
  logic              done_rise;
  logic              fire_q;

  // latch the core under test
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       sel_q <= '0;
    else if (csel_wr) sel_q <= csel_wdata;
  end

  // edge detector on the completion flag
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) done_d_q <= 1'b0;
    else        done_d_q <= done_q;
  end

  always_comb done_rise = done_q && !done_d_q;

  // registered reset request, high for one cycle
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) fire_q <= 1'b0;
    else        fire_q <= done_rise;
  end

  // activity code: a start wins over the idle return
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       act_q <= ACT_IDLE;
    else if (csel_wr) act_q <= ACT_RUN;
    else if (fire_q)  act_q <= ACT_IDLE;
  end

  assign act_code = act_q;

  // decode the latched index into one reset line per core
  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core_rst
    assign core_rst[gi] = fire_q && (sel_q == CSEL_W'(gi));
  end
endmodule

// File: rtl/bist_status_ctl.sv
module bist_status_ctl
  import bist_stat_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int CSEL_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 stat_wr,
  input  logic                 bus_priv,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    stat_rdata,
  input  logic                 key_wr,
  input  logic [CODE_W-1:0]    key_wdata,
  input  logic                 csel_wr,
  input  logic [CSEL_W-1:0]    csel_wdata,
  input  logic                 evt_done,
  input  logic                 evt_fail,
  input  logic                 evt_timeout,
  output logic [NUM_CORES-1:0] core_rst
);
  logic                key_arm;
  logic [FLAG_NUM-1:0] flag_set;
  logic [FLAG_NUM-1:0] flag_clr;
  logic [FLAG_NUM-1:0] flag_q;
  logic                done_q;
  stat_fields_t        fields;
  logic                unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:FLAG_NUM];

  bist_key_watch u_key (
    .clk       (clk),
    .por_n     (por_n),
    .key_wr    (key_wr),
    .key_wdata (key_wdata),
    .key_arm   (key_arm)
  );

  // set sources per flag
  always_comb begin
    flag_set           = '0;
    flag_set[DONE_IDX] = evt_done | evt_fail | evt_timeout;
    flag_set[FAIL_IDX] = evt_fail | evt_timeout;
  end

  for (genvar gf = 0; gf < FLAG_NUM; gf++) begin : g_flag
    assign flag_clr[gf] = key_arm | (stat_wr & bus_priv & bus_wdata[gf]);
    bist_flag_cell u_cell (
      .clk     (clk),
      .por_n   (por_n),
      .set_evt (flag_set[gf]),
      .clr_req (flag_clr[gf]),
      .flag_q  (flag_q[gf])
    );
  end

  assign done_q = flag_q[DONE_IDX];

  bist_run_seq #(
    .NUM_CORES (NUM_CORES),
    .CSEL_W    (CSEL_W)
  ) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .csel_wr    (csel_wr),
    .csel_wdata (csel_wdata),
    .done_q     (done_q),
    .act_code   (fields.act),
    .core_rst   (core_rst)
  );

  assign fields.flags = flag_q;

  // readback: unused bit positions are constant zero
  always_comb begin
    stat_rdata                        = '0;
    stat_rdata[FLAG_NUM-1:0]          = fields.flags;
    stat_rdata[ACT_LSB +: CODE_W]     = fields.act;
  end
endmodule

// File: rtl/bist_status_ctl_chk.sv
module bist_status_ctl_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int CSEL_W    = 2
) (
  input logic                 clk,
  input logic                 por_n,
  input logic                 stat_wr,
  input logic                 bus_priv,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    stat_rdata,
  input logic                 key_arm,
  input logic                 csel_wr,
  input logic                 evt_done,
  input logic                 evt_fail,
  input logic                 evt_timeout,
  input logic [NUM_CORES-1:0] core_rst
);
  logic evt_any;
  assign evt_any = evt_done | evt_fail | evt_timeout;

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    evt_any |=> stat_rdata[0]);

  assert_fail_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    (evt_fail || evt_timeout) |=> stat_rdata[1]);

  assert_clear_done_R3: assert property (@(posedge clk) disable iff (!por_n)
    (stat_wr && bus_priv && bus_wdata[0] && !evt_any) |=> !stat_rdata[0]);

  assert_user_keeps_done_R4: assert property (@(posedge clk) disable iff (!por_n)
    (stat_rdata[0] && !key_arm && !(stat_wr && bus_priv && bus_wdata[0])) |=> stat_rdata[0]);

  assert_key_clear_R5: assert property (@(posedge clk) disable iff (!por_n)
    (key_arm && !evt_any) |=> (stat_rdata[1:0] == 2'b00));

  assert_active_on_R6: assert property (@(posedge clk) disable iff (!por_n)
    csel_wr |=> (stat_rdata[11:8] == 4'hA));

  assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(core_rst));

  assert_pulse_after_rise_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stat_rdata[0]) |=> (core_rst != '0));

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst != '0) |=> (core_rst == '0));

  assert_active_off_R10: assert property (@(posedge clk) disable iff (!por_n)
    ((core_rst != '0) && !csel_wr) |=> (stat_rdata[11:8] == 4'h5));
endmodule

bind bist_status_ctl bist_status_ctl_chk #(
  .NUM_CORES (NUM_CORES),
  .DATA_W    (DATA_W),
  .CSEL_W    (CSEL_W)
) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .stat_wr     (stat_wr),
  .bus_priv    (bus_priv),
  .bus_wdata   (bus_wdata),
  .stat_rdata  (stat_rdata),
  .key_arm     (key_arm),
  .csel_wr     (csel_wr),
  .evt_done    (evt_done),
  .evt_fail    (evt_fail),
  .evt_timeout (evt_timeout),
  .core_rst    (core_rst)
);

// File: tb/bist_status_ctl_tb.sv
module bist_status_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          stat_wr = 1'b0, bus_priv = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] stat_rdata;
  logic          key_wr = 1'b0;
  logic [3:0]    key_wdata = '0;
  logic          csel_wr = 1'b0;
  logic [1:0]    csel_wdata = '0;
  logic          evt_done = 1'b0, evt_fail = 1'b0, evt_timeout = 1'b0;
  logic [NC-1:0] core_rst;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_status_ctl #(.NUM_CORES(NC), .DATA_W(DW)) u_dut (
    .clk(clk), .por_n(por_n), .stat_wr(stat_wr), .bus_priv(bus_priv),
    .bus_wdata(bus_wdata), .stat_rdata(stat_rdata), .key_wr(key_wr),
    .key_wdata(key_wdata), .csel_wr(csel_wr), .csel_wdata(csel_wdata),
    .evt_done(evt_done), .evt_fail(evt_fail), .evt_timeout(evt_timeout),
    .core_rst(core_rst)
  );

  typedef struct packed {
    logic        wr;
    logic        pr;
    logic [11:0] wd;
    logic        kw;
    logic [3:0]  kv;
    logic        cw;
    logic [1:0]  cs;
    logic        ed;
    logic        ef;
    logic        et;
    logic [11:0] erd;
    logic [3:0]  ers;
  } vec_t;

  // inputs for one cycle, then expected word low bits and reset lines after the edge
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b1,2'd2,1'b0,1'b0,1'b0,12'hA00,4'b0000}, // 0  R6 start core 2
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b1,1'b0,1'b0,12'hA01,4'b0000}, // 1  R7 clean done
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'hA01,4'b0100}, // 2  R9 pulse core 2
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h501,4'b0000}, // 3  R10 idle again
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h501,4'b0000}, // 4  R11 no repeat
    '{1'b1,1'b0,12'hFFF,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h501,4'b0000}, // 5  R4 user write
    '{1'b1,1'b1,12'hFFE,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h501,4'b0000}, // 6  R2 reserved/code write
    '{1'b1,1'b1,12'h001,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h500,4'b0000}, // 7  R3 clear done
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b1,2'd1,1'b0,1'b0,1'b0,12'hA00,4'b0000}, // 8  R6 start core 1
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b1,12'hA03,4'b0000}, // 9  R7 timeout
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'hA03,4'b0010}, // 10 R9 pulse core 1
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h503,4'b0000}, // 11 R10
    '{1'b1,1'b1,12'h002,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h501,4'b0000}, // 12 R3 clear fail only
    '{1'b0,1'b0,12'h000,1'b1,4'hA,1'b0,2'd0,1'b0,1'b0,1'b0,12'h500,4'b0000}, // 13 R5 key 5->A
    '{1'b1,1'b1,12'h003,1'b0,4'h0,1'b0,2'd0,1'b0,1'b1,1'b0,12'h503,4'b0000}, // 14 R8 set beats clear
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h503,4'b0010}, // 15 R11 new rise, new pulse
    '{1'b0,1'b0,12'h000,1'b1,4'hA,1'b0,2'd0,1'b0,1'b0,1'b0,12'h503,4'b0000}, // 16 R5 A->A no clear
    '{1'b0,1'b0,12'h000,1'b1,4'h3,1'b0,2'd0,1'b0,1'b0,1'b0,12'h503,4'b0000}, // 17 R5 disable
    '{1'b0,1'b0,12'h000,1'b1,4'hA,1'b0,2'd0,1'b0,1'b0,1'b0,12'h500,4'b0000}, // 18 R5 3->A
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b1,2'd3,1'b0,1'b1,1'b0,12'hA03,4'b0000}, // 19 R7 fail with start
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'hA03,4'b1000}, // 20 R9 pulse core 3
    '{1'b0,1'b0,12'h000,1'b0,4'h0,1'b0,2'd0,1'b0,1'b0,1'b0,12'h503,4'b0000}  // 21 R10
  };

  function automatic string req_of(int i);
    case (i)
      0, 8:             return "R6";
      1, 9, 19:         return "R7";
      2, 10, 20:        return "R9";
      3, 11, 21:        return "R10";
      4, 15:            return "R11";
      5:                return "R4";
      6:                return "R2";
      7, 12:            return "R3";
      14:               return "R8";
      default:          return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    stat_wr = 1'b0; bus_priv = 1'b0; bus_wdata = '0; key_wr = 1'b0; key_wdata = '0;
    csel_wr = 1'b0; csel_wdata = '0; evt_done = 1'b0; evt_fail = 1'b0; evt_timeout = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1", "reset word", stat_rdata, 32'h0000_0500);
    check("R1", "reset pulse", {28'd0, core_rst}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      stat_wr     = VEC[i].wr;
      bus_priv    = VEC[i].pr;
      bus_wdata   = {20'hFFFFF, VEC[i].wd};
      key_wr      = VEC[i].kw;
      key_wdata   = VEC[i].kv;
      csel_wr     = VEC[i].cw;
      csel_wdata  = VEC[i].cs;
      evt_done    = VEC[i].ed;
      evt_fail    = VEC[i].ef;
      evt_timeout = VEC[i].et;
      @(negedge clk);
      check(req_of(i), $sformatf("vec %0d word", i), stat_rdata, {20'd0, VEC[i].erd});
      check(req_of(i), $sformatf("vec %0d rst", i), {28'd0, core_rst}, {28'd0, VEC[i].ers});
    end
    idle_inputs();

    // R1: power-on reset from a non-idle state
    stat_wr = 1'b1; bus_priv = 1'b0; bus_wdata = '0;
    csel_wr = 1'b1; csel_wdata = 2'd1;
    @(negedge clk);
    idle_inputs();
    por_n = 1'b0;
    @(negedge clk);
    check("R1", "re-reset word", stat_rdata, 32'h0000_0500);
    check("R1", "re-reset pulse", {28'd0, core_rst}, 32'd0);
    por_n = 1'b1;
    @(negedge clk);

    // R5: key returns to disabled code on power-on, so 0xA arms again
    evt_timeout = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R7", "timeout after por", stat_rdata, 32'h0000_0503);
    key_wr = 1'b1; key_wdata = 4'hA;
    @(negedge clk);
    idle_inputs();
    check("R5", "key arm after por", stat_rdata, 32'h0000_0500);

    // R8: key transition and event in the same cycle
    key_wr = 1'b1; key_wdata = 4'h5;
    @(negedge clk);
    key_wdata = 4'hA; evt_done = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R8", "event beats key clear", stat_rdata, 32'h0000_0501);

    // R4: privileged write of zero to flags keeps them
    stat_wr = 1'b1; bus_priv = 1'b1; bus_wdata = 32'hFFFF_FFFC;
    @(negedge clk);
    idle_inputs();
    check("R4", "zero write", stat_rdata, 32'h0000_0501);

    finish_run();
  end
endmodule